// File: doc/BRIEF.md
# Multi-Length ARX Round Key Scheduler

This block expands a 128-, 192- or 256-bit master key into a series of 192-bit round keys. It uses only modular add or subtract, rotate and XOR-free constant mixing, so it suits a lightweight 128-bit block cipher core. A host starts a run with a key-length selection and a direction flag. It then streams the master key in 32-bit words. The scheduler then emits one round key per cipher round on a single-cycle strobe. The keys hold steady on the output until the next strobe, so the round datapath can consume them over its whole round.

The state sits in eight 32-bit registers split into two banks. The even bank holds registers 0, 2, 4 and 6 and the odd bank holds registers 1, 3, 5 and 7. Each bank has its own add/subtract-and-rotate lane, and the two lanes update one even-indexed and one odd-indexed state word per cycle. For decryption the block first runs the expansion forward to the final round. It then undoes one round at a time with subtraction and rotation in the opposite direction. This regenerates the keys from last to first with no stored key table.

Top module: `arx_key_sched`

## Requirements
- R1: `start` is taken only while idle. The first `key_we` word after it enters register 0 and the next enters register 1, alternating from then on. Each new word pushes the earlier ones along the chains 0→2→4→6 and 1→3→5→7. Key word k carries master key bits [32k+31:32k], and word 0 is sent first. There are 4, 6 or 8 words for mode 2'b00 (128-bit), 2'b01 (192-bit) and 2'b10 (256-bit). Mode 2'b11 behaves as 2'b00.
- R2: A run emits exactly 24, 28 or 32 round keys for the 128-, 192- and 256-bit modes, and no strobe follows the last key.
- R3: Consecutive strobes of a run are 3 cycles apart in the 128- and 192-bit modes and 4 cycles apart in the 256-bit mode.
- R4: In the 128-bit mode, the state T0..T3 starts as the key words. Round i uses constant c = rol(D[i mod 4], i). The base constants D[0..7] are c3efe9db, 44626b02, 79e27c8a, 78df30ec, 715ea49e, c785da0a, e04ef22a, e5c40957. Word j is updated as T_j = rol(T_j + rol(c, j), r_j), with r = 1, 3, 6, 11. Output words 0..5 on `rk[32j+31:32j]` are T0, T1, T2, T1, T3, T1.
- R5: In the 192-bit mode there are six words. The constant is rol(D[i mod 6], i), the rotations are r = 1, 3, 6, 11, 13, 17, and output word j is T_j.
- R6: In the 256-bit mode, step j (0..5) of round i updates word x = (6i+j) mod 8 as T_x = rol(T_x + rol(D[i mod 8], i+j), r_j). Output word j is T at (6i+j) mod 8.
- R7: With `decrypt` high, the same keys that encryption would give are emitted in reverse round order, last round first.
- R8: `rk_valid` is never high two cycles running, and `rk` changes only on a cycle in which `rk_valid` is high. A `start` pulse received during a run has no effect on that run's keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| mode | input | 2 | Key length: 00=128, 01=192, 10=256, 11=128 |
| decrypt | input | 1 | 1 emits keys in reverse round order |
| key_we | input | 1 | Key word strobe during loading |
| key_word | input | 32 | Master key word |
| rk_valid | output | 1 | One-cycle round key strobe |
| rk | output | 192 | Round key, word j at bits [32j+31:32j] |

## Verification
The bench builds the block with its default base-constant parameter, which is the standard eight-word constant set. With that set, every key of every round can be compared against an independent software expansion written straight from R4 to R6. All three key lengths are run in both directions, with more than one master key, so the mod-4, mod-6 and mod-8 constant indexing and the wrapping 256-bit word offsets all come into play. Strobe spacing and the count per run are checked to cover the three-cycle and four-cycle cadences. The reverse-order runs show that backward stepping exactly undoes the forward pass.

// File: rtl/arx_key_sched.sv
module arx_key_sched #(
  parameter logic [255:0] DELTA = 256'he5c40957_e04ef22a_c785da0a_715ea49e_78df30ec_79e27c8a_44626b02_c3efe9db
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         decrypt,
  input  logic         key_we,
  input  logic [31:0]  key_word,
  output logic         rk_valid,
  output logic [191:0] rk
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FWD, S_BWD} st_t;

  st_t         st;
  logic [1:0]  mode_q;
  logic        dec_q;
  logic [4:0]  rnd;
  logic [1:0]  ph;
  logic [2:0]  ldc;
  logic [31:0] t [8];
  logic        done_pulse;
  logic [4:0]  emit_idx;

  function automatic logic [31:0] rol(input logic [31:0] x, input logic [4:0] s);
    logic [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic logic [4:0] ramt(input logic [2:0] j);
    case (j)
      3'd0: return 5'd1;
      3'd1: return 5'd3;
      3'd2: return 5'd6;
      3'd3: return 5'd11;
      3'd4: return 5'd13;
      default: return 5'd17;
    endcase
  endfunction

  function automatic logic [31:0] lane(input logic [31:0] x, input logic [31:0] k,
                                       input logic [4:0] r, input logic fwd);
    if (fwd) return rol(x + k, r);
    else     return rol(x, 5'(5'd0 - r)) - k;
  endfunction

  function automatic logic [2:0] phys(input logic [2:0] l, input logic [2:0] eb);
    logic [2:0] b;
    b = eb - 3'd1 - {1'b0, l[2:1]};
    return {b[1:0], l[0]};
  endfunction

  wire m256 = (mode_q == 2'b10);
  wire m192 = (mode_q == 2'b01);
  wire m128 = !m256 && !m192;

  wire [2:0] ebank    = m256 ? 3'd4  : (m192 ? 3'd3  : 3'd2);
  wire [2:0] last_ld  = m256 ? 3'd7  : (m192 ? 3'd5  : 3'd3);
  wire [4:0] last_rnd = m256 ? 5'd31 : (m192 ? 5'd27 : 5'd23);
  wire [1:0] last_ph  = m256 ? 2'd3  : 2'd2;
  wire [1:0] last_cmp = m128 ? 2'd1  : 2'd2;

  wire running = (st == S_FWD) || (st == S_BWD);
  wire compute = running && (ph <= last_cmp);
  wire fwd     = (st == S_FWD);

  wire [1:0] q   = fwd ? ph : 2'(last_cmp - ph);
  wire [2:0] je  = {q, 1'b0};
  wire [2:0] jo  = {q, 1'b1};
  wire [2:0] off = m256 ? 3'(rnd * 5'd6) : 3'd0;
  wire [2:0] pe  = phys(3'(off + je), ebank);
  wire [2:0] po  = phys(3'(off + jo), ebank);

  wire [2:0]  cidx = m256 ? rnd[2:0] : (m192 ? 3'(rnd % 5'd6) : {1'b0, rnd[1:0]});
  wire [31:0] cst  = DELTA[{cidx, 5'b0} +: 32];
  wire [31:0] ke   = rol(cst, 5'(rnd + {2'b0, je}));
  wire [31:0] ko   = rol(cst, 5'(rnd + {2'b0, jo}));
  wire [31:0] ye   = lane(t[pe], ke, ramt(je), fwd);
  wire [31:0] yo   = lane(t[po], ko, ramt(jo), fwd);

  wire [2:0] eoff = 3'(emit_idx * 5'd6);

  function automatic logic [2:0] outsel(input logic [2:0] j, input logic a128,
                                        input logic a256, input logic [2:0] base);
    if (a256) return 3'(base + j);
    if (a128) begin
      case (j)
        3'd0: return 3'd0;
        3'd2: return 3'd2;
        3'd4: return 3'd3;
        default: return 3'd1;
      endcase
    end
    return j;
  endfunction

  logic [191:0] rk_mux;
  always_comb begin
    for (int j = 0; j < 6; j++)
      rk_mux[32*j +: 32] = t[phys(outsel(3'(j), m128, m256, eoff), ebank)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= 2'b00;
      dec_q      <= 1'b0;
      rnd        <= '0;
      ph         <= '0;
      ldc        <= '0;
      done_pulse <= 1'b0;
      emit_idx   <= '0;
      rk_valid   <= 1'b0;
      rk         <= '0;
      for (int i = 0; i < 8; i++) t[i] <= '0;
    end else begin
      done_pulse <= 1'b0;
      rk_valid   <= done_pulse;
      if (done_pulse) rk <= rk_mux;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          dec_q  <= decrypt;
          ldc    <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: if (key_we) begin
          if (!ldc[0]) begin
            t[6] <= t[4]; t[4] <= t[2]; t[2] <= t[0]; t[0] <= key_word;
          end else begin
            t[7] <= t[5]; t[5] <= t[3]; t[3] <= t[1]; t[1] <= key_word;
          end
          ldc <= ldc + 3'd1;
          if (ldc == last_ld) begin
            st  <= S_FWD;
            rnd <= '0;
            ph  <= '0;
          end
        end
        default: begin
          if (compute) begin
            t[pe] <= ye;
            t[po] <= yo;
          end
          if (ph == last_cmp && (!fwd || !dec_q || rnd == last_rnd)) begin
            done_pulse <= 1'b1;
            emit_idx   <= fwd ? rnd : rnd - 5'd1;
          end
          if (ph == last_ph) begin
            ph <= '0;
            if (fwd) begin
              if (rnd == last_rnd) st <= dec_q ? S_BWD : S_IDLE;
              else                 rnd <= rnd + 5'd1;
            end else begin
              if (rnd == 5'd1) st <= S_IDLE;
              else             rnd <= rnd - 5'd1;
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
      endcase
    end
  end

  p_load_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && key_we && !ldc[0]) |=> (t[0] == $past(key_word)));
  p_load_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && key_we && ldc[0]) |=> (t[1] == $past(key_word)));
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid |=> !rk_valid);
  p_rk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rk) |-> rk_valid);
  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rk_valid) |=> !rk_valid);
  p_round_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (rnd <= last_rnd && ph <= last_ph));

endmodule

// File: tb/sim_arx_key_sched.sv
module sim_arx_key_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic decrypt = 1'b0;
  logic key_we = 1'b0;
  logic [31:0] key_word = '0;
  logic rk_valid;
  logic [191:0] rk;

  int errors = 0;
  int checks = 0;
  logic [191:0] exp_rk [32];

  localparam logic [31:0] DL [8] = '{32'hc3efe9db, 32'h44626b02, 32'h79e27c8a, 32'h78df30ec,
                                    32'h715ea49e, 32'hc785da0a, 32'he04ef22a, 32'he5c40957};
  localparam int RT [6] = '{1, 3, 6, 11, 13, 17};

  always #2 clk = ~clk;

  arx_key_sched u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .decrypt(decrypt),
                    .key_we(key_we), .key_word(key_word), .rk_valid(rk_valid), .rk(rk));

  function automatic logic [31:0] brol(input logic [31:0] x, input int s);
    int m;
    m = s % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  function automatic void expand(input int len, input logic [255:0] key);
    logic [31:0] w [8];
    logic [31:0] d;
    int n;
    for (int j = 0; j < 8; j++) w[j] = key[32*j +: 32];
    n = (len == 256) ? 32 : (len == 192) ? 28 : 24;
    for (int i = 0; i < n; i++) begin
      if (len == 128) begin
        d = brol(DL[i % 4], i);
        for (int j = 0; j < 4; j++) w[j] = brol(w[j] + brol(d, j), RT[j]);
        exp_rk[i] = {w[1], w[3], w[1], w[2], w[1], w[0]};
      end else if (len == 192) begin
        d = brol(DL[i % 6], i);
        for (int j = 0; j < 6; j++) w[j] = brol(w[j] + brol(d, j), RT[j]);
        exp_rk[i] = {w[5], w[4], w[3], w[2], w[1], w[0]};
      end else begin
        for (int j = 0; j < 6; j++) begin
          int x;
          x = (6*i + j) % 8;
          w[x] = brol(w[x] + brol(DL[i % 8], i + j), RT[j]);
          exp_rk[i][32*j +: 32] = w[x];
        end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] md, input bit dec, input logic [255:0] key,
                     input bit poke, input string req);
    int len, n, per, cyc, last, extra;
    len = (md == 2'b10) ? 256 : (md == 2'b01) ? 192 : 128;
    n   = (len == 256) ? 32 : (len == 192) ? 28 : 24;
    per = (len == 256) ? 4 : 3;
    expand(len, key);
    @(negedge clk);
    start = 1'b1; mode = md; decrypt = dec;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len / 32; k++) begin
      key_we = 1'b1; key_word = key[32*k +: 32];
      @(negedge clk);
    end
    key_we = 1'b0;
    cyc = 0; last = 0;
    for (int r = 0; r < n; r++) begin
      int tmo;
      bit got;
      tmo = 0; got = 1'b0;
      while (!got && tmo < 400) begin
        if (rk_valid) got = 1'b1;
        else begin @(negedge clk); cyc++; tmo++; end
      end
      chk(got, "R2 strobe present", 192'(r), 192'(n));
      if (!got) return;
      chk(rk == exp_rk[dec ? n-1-r : r], dec ? "R7 reverse key" : req, rk, exp_rk[dec ? n-1-r : r]);
      if (r > 0) chk(cyc - last == per, "R3 strobe spacing", 192'(cyc - last), 192'(per));
      last = cyc;
      @(negedge clk); cyc++;
      chk(!rk_valid, "R8 single-cycle strobe", 192'(rk_valid), 192'(0));
      if (poke && r == 2) begin
        start = 1'b1; mode = 2'b10; decrypt = ~dec;
        @(negedge clk); cyc++;
        start = 1'b0;
      end
    end
    extra = 0;
    repeat (12) begin
      @(negedge clk);
      if (rk_valid) extra++;
    end
    chk(extra == 0, "R2 no strobe after last key", 192'(extra), 192'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] ka, kb;
    ka = 256'h1f1e1d1c_1b1a1918_17161514_13121110_0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    kb = 256'hdeadbeef_01234567_89abcdef_fedcba98_76543210_0badf00d_55aa33cc_a5a5a5a5;
    repeat (3) @(negedge clk);
    chk(rk_valid == 1'b0 && rk == '0, "R8 reset state", rk, '0);
    rst_n = 1'b1;
    @(negedge clk);
    run(2'b00, 1'b0, ka, 1'b1, "R4 128-bit key (R1 load, R8 start ignored)");
    run(2'b00, 1'b0, kb, 1'b0, "R4 128-bit key");
    run(2'b01, 1'b0, ka, 1'b0, "R5 192-bit key");
    run(2'b01, 1'b0, kb, 1'b0, "R5 192-bit key");
    run(2'b10, 1'b0, ka, 1'b0, "R6 256-bit key");
    run(2'b10, 1'b0, kb, 1'b0, "R6 256-bit key");
    run(2'b00, 1'b1, kb, 1'b0, "R7 128-bit reverse");
    run(2'b01, 1'b1, ka, 1'b0, "R7 192-bit reverse");
    run(2'b10, 1'b1, kb, 1'b1, "R7 256-bit reverse");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule